// File: doc/BRIEF.md
# Slave-SPI Configuration Sequencer for SRAM FPGAs

This block loads a configuration image into an SRAM-based FPGA through the device's slave SPI port. A single start pulse makes it pull chip-select low, hold the device's configuration reset low for 2 ms, release it, and then wait 200 ms while the device clears its configuration memory. After that it takes image bytes from a ready/valid byte stream and shifts each one out MSB first on a mode-0 SPI link.

When the byte flagged as last has been shifted out, the sequencer sends 12 trailing bytes of 0xFF, which gives 96 extra clocks. It can also send 7 further 0xFF bytes (56 clocks), so that the device's configuration pins become free for general I/O. The sequencer then raises chip-select again and pulses `done_o` for one cycle.

Both delays are derived from a system-clock frequency parameter. A divisor parameter can shorten them for simulation. The SCK half-period is a whole number of system clocks.

Top module: `fpga_cfg_seq`

## Requirements
- R1: Out of reset, and whenever the block is idle, `spi_cs_n_o` and `cfg_rst_n_o` are 1, while `spi_sck_o`, `busy_o`, `img_ready_o` and `done_o` are 0.
- R2: On the cycle after `start_i` is sampled while idle, `spi_cs_n_o` is 0 and `cfg_rst_n_o` is still 1. One cycle later, `cfg_rst_n_o` goes to 0.
- R3: `cfg_rst_n_o` stays low for exactly RST_CYC = CLK_HZ/1000*2/TIME_DIV cycles, then returns high.
- R4: After `cfg_rst_n_o` rises, `img_ready_o` first asserts exactly CLR_CYC = CLK_HZ/1000*200/TIME_DIV cycles later. No SCK edge occurs before that point.
- R5: Each byte is sent MSB first in SPI mode 0. SCK idles at 0, MOSI holds steady at every SCK rising edge, and each SCK level lasts SCK_HALF system clocks.
- R6: A byte is taken only on a cycle where both `img_valid_i` and `img_ready_o` are 1. `img_ready_o` stays 0 while a byte is being shifted. Data offered with `img_valid_i` at 0 is never sent.
- R7: After the byte marked by `img_last_i` has been shifted out, exactly 12 bytes of 0xFF follow (96 SCK rising edges).
- R8: If `keep_pins_i` is 1 when start is accepted, 19 bytes of 0xFF follow the image instead of 12 (152 SCK rising edges).
- R9: In the cycle where `spi_cs_n_o` returns to 1, `done_o` is 1 for that cycle only and `busy_o` is 0.
- R10: `start_i` has no effect unless the block is idle. This includes a start during the data phase and a start in the `done_o` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begins a configuration run when idle |
| keep_pins_i | input | 1 | Requests the extra 7 dummy bytes; captured at start |
| img_valid_i | input | 1 | Image byte available |
| img_data_i | input | 8 | Image byte |
| img_last_i | input | 1 | Marks the final image byte |
| img_ready_o | output | 1 | Sequencer can take an image byte |
| spi_sck_o | output | 1 | SPI clock, mode 0 |
| spi_mosi_o | output | 1 | SPI data to the device |
| spi_cs_n_o | output | 1 | Active-low chip-select |
| cfg_rst_n_o | output | 1 | Active-low configuration reset to the device |
| busy_o | output | 1 | High from start until chip-select is released |
| done_o | output | 1 | One-cycle pulse when the run completes |

## Verification
Two events can coincide: a fresh `start_i` and the completion cycle in which `done_o` pulses and chip-select rises. The bench drives `start_i` exactly on that cycle and then checks that chip-select stays high and `busy_o` stays low on the next cycle. A second coincidence is a start pulse arriving while an image byte is being handshaked. The bench judges that case through the scoreboard, which must see the bit stream continue unchanged, and through the reset line, which must not drop again.

// File: rtl/cfg_seq_pkg.sv
package cfg_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CSLO,
    ST_RSTLO,
    ST_CLEAR,
    ST_DATA,
    ST_DUMMY,
    ST_DONE
  } seq_state_t;

  localparam int unsigned TRAIL_BYTES = 12;
  localparam int unsigned FREE_BYTES  = 7;
  localparam logic [7:0]  FILL_BYTE   = 8'hFF;

  // cycles for a delay of ms milliseconds, divided by scale, never below 1
  function automatic longint unsigned delay_cycles(input longint unsigned clk_hz,
                                                   input longint unsigned ms,
                                                   input longint unsigned scale);
    longint unsigned c;
    c = (clk_hz / 1000) * ms / scale;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned trail_count(input logic keep);
    return keep ? (TRAIL_BYTES + FREE_BYTES) : TRAIL_BYTES;
  endfunction

endpackage

// File: rtl/cfg_delay_timer.sv
module cfg_delay_timer #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (load_i)       cnt <= val_i - W'(1);
    else if (cnt != '0)    cnt <= cnt - W'(1);
  end

  assign zero_o = (cnt == '0);
endmodule

// File: rtl/spi_byte_shifter.sv
module spi_byte_shifter #(
  parameter int unsigned HALF = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load_i,
  input  logic [7:0] byte_i,
  output logic       active_o,
  output logic       sck_o,
  output logic       mosi_o
);
  localparam int unsigned HW = (HALF > 1) ? $clog2(HALF) : 1;

  logic [HW-1:0] hcnt;
  logic [2:0]    bit_q;
  logic          ph;
  logic          act;
  logic [7:0]    sh;

  wire half_end  = (hcnt == HW'(HALF - 1));
  wire fall_evt  = act && half_end && ph;
  wire byte_end  = fall_evt && (bit_q == 3'd7);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt <= '0; bit_q <= '0; ph <= 1'b0; act <= 1'b0; sh <= '0;
    end else if (load_i && !act) begin
      act <= 1'b1; sh <= byte_i; bit_q <= '0; ph <= 1'b0; hcnt <= '0;
    end else if (act) begin
      if (half_end) begin
        hcnt <= '0;
        ph   <= ~ph;
        if (byte_end)      act <= 1'b0;
        else if (fall_evt) begin
          bit_q <= bit_q + 3'd1;
          sh    <= {sh[6:0], 1'b0};
        end
      end else begin
        hcnt <= hcnt + HW'(1);
      end
    end
  end

  assign active_o = act;
  assign sck_o    = ph;
  assign mosi_o   = sh[7];

  // R5
  mosi_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sck_o) |-> $stable(mosi_o));

  // R5
  sck_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !act |-> !sck_o);
endmodule

// File: rtl/fpga_cfg_seq.sv
module fpga_cfg_seq
  import cfg_seq_pkg::*;
#(
  parameter longint unsigned CLK_HZ   = 250_000_000,
  parameter longint unsigned TIME_DIV = 1,
  parameter int unsigned     SCK_HALF = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       keep_pins_i,
  input  logic       img_valid_i,
  input  logic [7:0] img_data_i,
  input  logic       img_last_i,
  output logic       img_ready_o,
  output logic       spi_sck_o,
  output logic       spi_mosi_o,
  output logic       spi_cs_n_o,
  output logic       cfg_rst_n_o,
  output logic       busy_o,
  output logic       done_o
);
  localparam longint unsigned RST_CYC = delay_cycles(CLK_HZ, 2, TIME_DIV);
  localparam longint unsigned CLR_CYC = delay_cycles(CLK_HZ, 200, TIME_DIV);
  localparam longint unsigned MAX_CYC = (CLR_CYC > RST_CYC) ? CLR_CYC : RST_CYC;
  localparam int unsigned     TW      = $clog2(MAX_CYC + 1);
  localparam int unsigned     DW      = $clog2(TRAIL_BYTES + FREE_BYTES + 1);

  seq_state_t st, nxt;
  logic          last_seen;
  logic [DW-1:0] dsent, target;
  logic          tmr_load, tmr_zero;
  logic [TW-1:0] tmr_val;
  logic          tx_load, tx_active;
  logic [7:0]    tx_byte;

  cfg_delay_timer #(.W(TW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load_i(tmr_load), .val_i(tmr_val), .zero_o(tmr_zero)
  );

  spi_byte_shifter #(.HALF(SCK_HALF)) u_shift (
    .clk(clk), .rst_n(rst_n), .load_i(tx_load), .byte_i(tx_byte),
    .active_o(tx_active), .sck_o(spi_sck_o), .mosi_o(spi_mosi_o)
  );

  assign img_ready_o = (st == ST_DATA) && !last_seen && !tx_active;
  assign busy_o      = (st != ST_IDLE) && (st != ST_DONE);
  assign spi_cs_n_o  = !busy_o;
  assign cfg_rst_n_o = (st != ST_RSTLO);
  assign done_o      = (st == ST_DONE);

  wire img_take   = img_valid_i && img_ready_o;
  wire fill_left  = (dsent != target);

  always_comb begin
    nxt      = st;
    tmr_load = 1'b0;
    tmr_val  = TW'(RST_CYC);
    tx_load  = 1'b0;
    tx_byte  = img_data_i;
    case (st)
      ST_IDLE:  if (start_i) nxt = ST_CSLO;
      ST_CSLO: begin
        tmr_load = 1'b1;
        nxt      = ST_RSTLO;
      end
      ST_RSTLO: if (tmr_zero) begin
        tmr_load = 1'b1;
        tmr_val  = TW'(CLR_CYC);
        nxt      = ST_CLEAR;
      end
      ST_CLEAR: if (tmr_zero) nxt = ST_DATA;
      ST_DATA: begin
        if (last_seen && !tx_active) nxt = ST_DUMMY;
        else                         tx_load = img_take;
      end
      ST_DUMMY: if (!tx_active) begin
        if (fill_left) begin
          tx_load = 1'b1;
          tx_byte = FILL_BYTE;
        end else begin
          nxt = ST_DONE;
        end
      end
      ST_DONE:  nxt = ST_IDLE;
      default:  nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; last_seen <= 1'b0; dsent <= '0; target <= '0;
    end else begin
      st <= nxt;
      if (st == ST_IDLE && start_i) begin
        last_seen <= 1'b0;
        dsent     <= '0;
        target    <= DW'(trail_count(keep_pins_i));
      end
      if (st == ST_DATA && img_take && img_last_i) last_seen <= 1'b1;
      if (st == ST_DUMMY && tx_load) dsent <= dsent + DW'(1);
    end
  end

  // cycles the configuration reset has been held low, for the width check
  logic [TW-1:0] rst_low_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            rst_low_cnt <= '0;
    else if (!cfg_rst_n_o) rst_low_cnt <= rst_low_cnt + TW'(1);
    else                   rst_low_cnt <= '0;
  end

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (spi_cs_n_o && !spi_sck_o && cfg_rst_n_o));

  // R3
  rst_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_rst_n_o) |-> (rst_low_cnt == TW'(RST_CYC)));

  // R4
  no_clock_early_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_CSLO || st == ST_RSTLO || st == ST_CLEAR) |-> !spi_sck_o);

  // R6
  load_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_load |=> tx_active);

  // R7 R8
  fill_total_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> (dsent == target) && !tx_active);

  // R9
  done_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $rose(spi_cs_n_o) && !busy_o);

  // R10
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i && st != ST_CSLO) |=> busy_o || done_o);
endmodule

// File: tb/fpga_cfg_seq_tb.sv
module fpga_cfg_seq_tb;
  localparam longint unsigned CLK_HZ = 250_000_000;
  localparam longint unsigned DIV    = 50_000;
  localparam int unsigned     HALF   = 2;
  localparam int RST_EXP = int'((CLK_HZ / 1000) * 2 / DIV);
  localparam int CLR_EXP = int'((CLK_HZ / 1000) * 200 / DIV);

  logic clk = 1'b0, rst_n = 1'b0;
  logic start_i = 1'b0, keep_pins_i = 1'b0, img_valid_i = 1'b0, img_last_i = 1'b0;
  logic [7:0] img_data_i = 8'h00;
  logic img_ready_o, spi_sck_o, spi_mosi_o, spi_cs_n_o, cfg_rst_n_o, busy_o, done_o;

  always #2 clk = ~clk;

  fpga_cfg_seq #(.CLK_HZ(CLK_HZ), .TIME_DIV(DIV), .SCK_HALF(HALF)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .keep_pins_i(keep_pins_i),
    .img_valid_i(img_valid_i), .img_data_i(img_data_i), .img_last_i(img_last_i),
    .img_ready_o(img_ready_o), .spi_sck_o(spi_sck_o), .spi_mosi_o(spi_mosi_o),
    .spi_cs_n_o(spi_cs_n_o), .cfg_rst_n_o(cfg_rst_n_o), .busy_o(busy_o), .done_o(done_o)
  );

  int n_cmp = 0, n_bad = 0;
  logic [7:0] exp_q[$];
  logic [7:0] sr = 8'h00;
  int bits = 0, edges = 0;
  int sck_hi_len = 0;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // monitor: rebuild bytes at SCK rising edges, compare with the scoreboard queue
  always @(posedge spi_sck_o) begin
    edges++;
    sr = {sr[6:0], spi_mosi_o};
    bits++;
    check(!spi_cs_n_o, "R5 chip-select low at SCK edge", spi_cs_n_o, 0);
    if (bits == 8) begin
      bits = 0;
      if (exp_q.size() == 0) check(1'b0, "R6 unexpected byte", sr, -1);
      else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        check(sr == e, "R5 R7 byte on MOSI", sr, e);
      end
    end
  end

  // SCK high time measured in system clocks (R5)
  always @(negedge clk) begin
    if (spi_sck_o) sck_hi_len++;
    else begin
      if (sck_hi_len != 0) check(sck_hi_len == HALF, "R5 SCK high width", sck_hi_len, HALF);
      sck_hi_len = 0;
    end
  end

  function automatic logic [7:0] pat(input int seed, input int i);
    if (i == 0) return 8'h80;
    if (i == 1) return 8'h01;
    return 8'((i * 37 + seed * 11) ^ 8'h5C);
  endfunction

  task automatic run(input int n, input bit keep, input bit gaps, input int seed,
                     input bit poke_mid, input bit poke_done);
    int rl, cl, nfill;
    nfill = keep ? 19 : 12;
    for (int i = 0; i < n; i++) exp_q.push_back(pat(seed, i));
    for (int i = 0; i < nfill; i++) exp_q.push_back(8'hFF);
    edges = 0;
    @(negedge clk);
    keep_pins_i = keep;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    keep_pins_i = ~keep;
    check(spi_cs_n_o == 0 && cfg_rst_n_o == 1, "R2 chip-select first", {spi_cs_n_o, cfg_rst_n_o}, 1);
    @(negedge clk);
    check(cfg_rst_n_o == 0, "R2 reset low next", cfg_rst_n_o, 0);
    rl = 1;
    while (!cfg_rst_n_o) begin
      @(negedge clk);
      if (!cfg_rst_n_o) rl++;
    end
    check(rl == RST_EXP, "R3 reset width", rl, RST_EXP);
    cl = 0;
    while (!img_ready_o && cl < CLR_EXP + 10) begin
      cl++;
      @(negedge clk);
    end
    check(cl == CLR_EXP, "R4 clear wait", cl, CLR_EXP);
    check(edges == 0, "R4 no SCK before data", edges, 0);
    for (int i = 0; i < n; i++) begin
      if (gaps && (i % 3 == 1)) begin
        img_valid_i = 1'b0;
        img_data_i  = 8'hA5;
        img_last_i  = 1'b1;
        repeat (5) @(negedge clk);
      end
      img_valid_i = 1'b1;
      img_data_i  = pat(seed, i);
      img_last_i  = (i == n - 1);
      while (!img_ready_o) @(negedge clk);
      if (poke_mid && i == n / 2) start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      img_valid_i = 1'b0;
      img_last_i  = 1'b0;
      if (i == n - 1) check(img_ready_o == 0, "R6 ready low after last", img_ready_o, 0);
    end
    while (!done_o) @(negedge clk);
    check(spi_cs_n_o == 1 && busy_o == 0, "R9 release with done", {spi_cs_n_o, busy_o}, 2);
    check(edges == 8 * (n + nfill), keep ? "R8 extra fill clocks" : "R7 fill clocks",
          edges, 8 * (n + nfill));
    check(exp_q.size() == 0, "R7 scoreboard drained", exp_q.size(), 0);
    check(cfg_rst_n_o == 1, "R10 reset not re-entered", cfg_rst_n_o, 1);
    if (poke_done) start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check(done_o == 0, "R9 done one cycle", done_o, 0);
    check(spi_cs_n_o == 1 && busy_o == 0, "R10 start at done ignored", {spi_cs_n_o, busy_o}, 2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(spi_cs_n_o == 1 && cfg_rst_n_o == 1 && spi_sck_o == 0 && busy_o == 0
          && img_ready_o == 0 && done_o == 0, "R1 reset state",
          {spi_cs_n_o, cfg_rst_n_o, spi_sck_o, busy_o, img_ready_o, done_o}, 6'b110000);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(busy_o == 0 && spi_cs_n_o == 1, "R1 idle after reset", busy_o, 0);
    run(6,  1'b0, 1'b0, 1, 1'b0, 1'b0);
    run(10, 1'b1, 1'b1, 2, 1'b1, 1'b1);
    run(1,  1'b0, 1'b0, 3, 1'b0, 1'b1);
    run(16, 1'b1, 1'b0, 4, 1'b1, 1'b0);
    repeat (4) @(negedge clk);
    check(busy_o == 0 && spi_sck_o == 0, "R1 idle at end", busy_o, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule